// File: doc/BRIEF.md
# Framebuffer Write-Paging Decoder

This block sits between a CPU and a 48 KB byte-per-pixel bitmap memory. The memory holds a 256-pixel-wide, 192-line layer. A one-byte control port sets four things: whether the layer is shown, whether the shadow copy of the memory is selected, whether write paging is on, and which third of the screen is being paged. While paging is on, CPU writes to the lowest 16 KB of the address space are steered into the chosen 16 KB bank of pixel memory. In the same cycle, the block tells the system ROM to release the bus for that write.

Pixels are stored row by row with no interlacing. Inside the window, the high address byte is the line within the selected third and the low byte is the X coordinate. The pixel memory address is the two bank bits placed above the 14 window bits. Bank code 3 does not exist and blocks the write. All other accesses pass through unchanged, and the pixel memory is not written for them.

Top module: `fbp_write_pager`

## Requirements
- R1: After reset the control byte is 0x00, so layer_visible_o, shadow_sel_o, pix_we_o and rom_off_o are all low.
- R2: A port write stores port_data_i at the clock edge. From the next cycle, layer_visible_o equals stored bit 1 and shadow_sel_o equals stored bit 3. Without a port write the stored byte holds.
- R3: With paging on (bit 0) and bank code b = bits 7:6 in {0,1,2}, a CPU write to address a < 0x4000 produces pix_we_o high for exactly one cycle, starting one cycle later. In that cycle pix_addr_o = b*0x4000 + a and pix_data_o equals the written byte.
- R4: For a redirected write, pix_addr_o[7:0] is the X coordinate a[7:0], and pix_addr_o[15:8] is the absolute line number b*64 + a[13:8].
- R5: CPU writes to addresses 0x4000 and above never assert pix_we_o or rom_off_o.
- R6: While bit 0 is clear, no CPU write asserts pix_we_o or rom_off_o.
- R7: With bank code 3 and paging on, writes in the window assert neither pix_we_o nor rom_off_o.
- R8: rom_off_o is high, combinationally and in the same cycle, exactly while cpu_wr_i carries a write that is being redirected.
- R9: Control bits 5, 4 and 2 have no effect on any output.
- R10: A CPU write in the same cycle as a port write is decoded with the control byte held before that port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_wr_i | input | 1 | Control port write strobe |
| port_data_i | input | 8 | Control byte |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU memory write strobe |
| pix_addr_o | output | 16 | Pixel memory address |
| pix_data_o | output | 8 | Pixel memory write data |
| pix_we_o | output | 1 | Pixel memory write enable |
| layer_visible_o | output | 1 | Layer shown |
| shadow_sel_o | output | 1 | Shadow memory selected |
| rom_off_o | output | 1 | ROM must stay off the bus |

## Verification
Inputs are driven on the falling edge. rom_off_o is combinational, so it is sampled 1 ns after the write is applied, in the same cycle. The control flags and the pixel-memory write each pass through one register. They are therefore sampled on the falling edge after the next rising edge, and pix_we_o is sampled once more a cycle later to confirm it lasts one cycle. Each check that a write was suppressed looks at both the same-cycle flag and the registered enable in those same two slots.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int CTRL_W = 8;
  localparam int BANK_W = 2;

  // bank field position is decoded behaviour; spare bits are kept but unused
  typedef struct packed {
    logic [1:0] bank;
    logic [1:0] spare_hi;
    logic       shadow;
    logic       spare_lo;
    logic       visible;
    logic       paging;
  } ctrl_t;
endpackage

// File: rtl/fbp_ctrl_reg.sv
module fbp_ctrl_reg
  import fbp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_wr_i,
  input  logic [CTRL_W-1:0] port_data_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              paging_o,
  output logic              visible_o,
  output logic              shadow_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (port_wr_i) ctrl_q <= ctrl_t'(port_data_i);
  end

  assign bank_o    = ctrl_q.bank;
  assign paging_o  = ctrl_q.paging;
  assign visible_o = ctrl_q.visible;
  assign shadow_o  = ctrl_q.shadow;

  assert_port_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_i |=> ctrl_q == $past(port_data_i));
  assert_port_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/fbp_addr_decode.sv
module fbp_addr_decode
  import fbp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_W     = 14,
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_wr_i,
  input  logic              paging_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              redirect_o
);
  localparam int HI_W = ADDR_W - WIN_W;

  logic in_window, bank_ok;

  assign in_window  = (cpu_addr_i[ADDR_W-1:WIN_W] == HI_W'(0));
  assign bank_ok    = (int'(bank_i) < NUM_BANKS);
  assign redirect_o = cpu_wr_i & paging_i & in_window & bank_ok;
endmodule

// File: rtl/fbp_wr_stage.sv
module fbp_wr_stage
  import fbp_pkg::*;
#(
  parameter int WIN_W  = 14,
  parameter int DATA_W = 8,
  localparam int PIX_AW = BANK_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redirect_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [WIN_W-1:0]  offs_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PIX_AW-1:0] pix_addr_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              pix_we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_we_o   <= 1'b0;
      pix_addr_o <= '0;
      pix_data_o <= '0;
    end else begin
      pix_we_o <= redirect_i;
      if (redirect_i) begin
        pix_addr_o <= {bank_i, offs_i};
        pix_data_o <= data_i;
      end
    end
  end

  assert_no_bank3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |-> pix_addr_o[PIX_AW-1 -: BANK_W] != 2'b11);
  assert_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> pix_we_o && pix_data_o == $past(data_i));
endmodule

// File: rtl/fbp_write_pager.sv
module fbp_write_pager
  import fbp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WIN_W     = 14,
  parameter int NUM_BANKS = 3,
  localparam int PIX_AW   = BANK_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_wr_i,
  input  logic [CTRL_W-1:0] port_data_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_wr_i,
  output logic [PIX_AW-1:0] pix_addr_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              pix_we_o,
  output logic              layer_visible_o,
  output logic              shadow_sel_o,
  output logic              rom_off_o
);
  logic [BANK_W-1:0] bank;
  logic              paging, redirect;

  fbp_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .port_wr_i, .port_data_i,
    .bank_o(bank), .paging_o(paging),
    .visible_o(layer_visible_o), .shadow_o(shadow_sel_o)
  );

  fbp_addr_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .cpu_addr_i, .cpu_wr_i, .paging_i(paging), .bank_i(bank), .redirect_o(redirect)
  );

  fbp_wr_stage #(.WIN_W(WIN_W), .DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni, .redirect_i(redirect), .bank_i(bank),
    .offs_i(cpu_addr_i[WIN_W-1:0]), .data_i(cpu_data_i),
    .pix_addr_o, .pix_data_o, .pix_we_o
  );

  assign rom_off_o = redirect;

  assert_outside_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[ADDR_W-1:WIN_W] != '0) |=> !pix_we_o);
  assert_paging_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !paging) |=> !pix_we_o);
  assert_rom_off_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_off_o |-> cpu_wr_i);
endmodule

// File: tb/fbp_write_pager_tb.sv
module fbp_write_pager_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        port_wr_i = 1'b0;
  logic [7:0]  port_data_i = '0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic [15:0] pix_addr_o;
  logic [7:0]  pix_data_o;
  logic        pix_we_o, layer_visible_o, shadow_sel_o, rom_off_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  fbp_write_pager dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic port_write(input logic [7:0] v);
    @(negedge clk_i);
    port_wr_i = 1'b1; port_data_i = v;
    @(negedge clk_i);
    port_wr_i = 1'b0;
  endtask

  // drives one write; expect_redir selects whether it should be redirected
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                           input bit expect_redir, input logic [15:0] exp_pa, input string req);
    @(negedge clk_i);
    cpu_wr_i = 1'b1; cpu_addr_i = a; cpu_data_i = d;
    #1;
    chk(rom_off_o == expect_redir, {req, " rom_off"}, rom_off_o, expect_redir);
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    chk(pix_we_o == expect_redir, {req, " pix_we"}, pix_we_o, expect_redir);
    if (expect_redir) begin
      chk(pix_addr_o == exp_pa, {req, " pix_addr"}, pix_addr_o, exp_pa);
      chk(pix_data_o == d, {req, " pix_data"}, pix_data_o, d);
    end
    @(negedge clk_i);
    chk(pix_we_o == 1'b0, {req, " we pulse"}, pix_we_o, 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(layer_visible_o == 0 && shadow_sel_o == 0, "R1 flags", {shadow_sel_o, layer_visible_o}, 0);
    chk(pix_we_o == 0 && rom_off_o == 0, "R1 write", {pix_we_o, rom_off_o}, 0);
    cpu_write(16'h0100, 8'h55, 0, 16'h0, "R1 paging off after reset");
  endtask

  task automatic t_port_fields;
    port_write(8'h02);
    chk(layer_visible_o == 1 && shadow_sel_o == 0, "R2 visible", {shadow_sel_o, layer_visible_o}, 1);
    port_write(8'h08);
    chk(layer_visible_o == 0 && shadow_sel_o == 1, "R2 shadow", {shadow_sel_o, layer_visible_o}, 2);
    repeat (3) @(negedge clk_i);
    chk(shadow_sel_o == 1, "R2 hold", shadow_sel_o, 1);
  endtask

  task automatic t_bank_writes;
    port_write(8'h01);
    cpu_write(16'h0000, 8'hA1, 1, 16'h0000, "R3 bank0 first");
    port_write(8'h41);
    cpu_write(16'h3FFF, 8'hB2, 1, 16'h7FFF, "R3 bank1 last");
    port_write(8'h81);
    cpu_write(16'h1234, 8'hC3, 1, 16'h9234, "R3 bank2");
  endtask

  task automatic t_coords;
    port_write(8'h81);
    cpu_write(16'h2A05, 8'h7E, 1, 16'hAA05, "R4 coords");
    chk(pix_addr_o[7:0] == 8'h05, "R4 x", pix_addr_o[7:0], 5);
    chk(pix_addr_o[15:8] == 8'd170, "R4 line", pix_addr_o[15:8], 170);
  endtask

  task automatic t_outside;
    port_write(8'h41);
    cpu_write(16'h4000, 8'h11, 0, 16'h0, "R5 0x4000");
    cpu_write(16'hFFFF, 8'h12, 0, 16'h0, "R5 0xFFFF");
    cpu_write(16'h8123, 8'h13, 0, 16'h0, "R5 0x8123");
  endtask

  task automatic t_paging_off;
    port_write(8'h80);
    cpu_write(16'h0010, 8'h21, 0, 16'h0, "R6 bank2 off");
    port_write(8'h4A);
    cpu_write(16'h3000, 8'h22, 0, 16'h0, "R6 visible off");
  endtask

  task automatic t_bank3;
    port_write(8'hC1);
    cpu_write(16'h0000, 8'h31, 0, 16'h0, "R7 bank3 low");
    cpu_write(16'h3FFF, 8'h32, 0, 16'h0, "R7 bank3 high");
  endtask

  task automatic t_rom_off_idle;
    port_write(8'h01);
    @(negedge clk_i);
    cpu_addr_i = 16'h0200; cpu_wr_i = 1'b0;
    #1;
    chk(rom_off_o == 0, "R8 no write no rom_off", rom_off_o, 0);
    cpu_write(16'h0200, 8'h44, 1, 16'h0200, "R8 redirect");
  endtask

  task automatic t_spare_bits;
    port_write(8'h34);
    chk(layer_visible_o == 0 && shadow_sel_o == 0, "R9 spare flags", {shadow_sel_o, layer_visible_o}, 0);
    cpu_write(16'h0100, 8'h51, 0, 16'h0, "R9 spare no paging");
    port_write(8'h75);
    chk(layer_visible_o == 0 && shadow_sel_o == 0, "R9 spare flags 2", {shadow_sel_o, layer_visible_o}, 0);
    cpu_write(16'h0100, 8'h52, 1, 16'h4100, "R9 spare bank1");
  endtask

  task automatic t_same_cycle;
    port_write(8'h00);
    @(negedge clk_i);
    port_wr_i = 1'b1; port_data_i = 8'h81;
    cpu_wr_i = 1'b1; cpu_addr_i = 16'h0300; cpu_data_i = 8'h66;
    #1;
    chk(rom_off_o == 0, "R10 old ctrl rom_off", rom_off_o, 0);
    @(negedge clk_i);
    port_wr_i = 1'b0; cpu_wr_i = 1'b0;
    chk(pix_we_o == 0, "R10 old ctrl pix_we", pix_we_o, 0);
    port_write(8'h01);
    @(negedge clk_i);
    port_wr_i = 1'b1; port_data_i = 8'h00;
    cpu_wr_i = 1'b1; cpu_addr_i = 16'h0301; cpu_data_i = 8'h67;
    #1;
    chk(rom_off_o == 1, "R10 old ctrl on rom_off", rom_off_o, 1);
    @(negedge clk_i);
    port_wr_i = 1'b0; cpu_wr_i = 1'b0;
    chk(pix_we_o == 1 && pix_addr_o == 16'h0301, "R10 old ctrl on write", pix_addr_o, 16'h0301);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_port_fields();
    t_bank_writes();
    t_coords();
    t_outside();
    t_paging_off();
    t_bank3();
    t_rom_off_idle();
    t_spare_bits();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule